// File: doc/BRIEF.md
# Data Memory Access Router

This block sits between an 8051-style core and the memories around it. For every data access the core presents an access-type code, a 16-bit address and a read or write strobe. The router raises exactly one select toward the memory that owns the location: lower internal RAM, upper internal RAM, the special function register space, its own auxiliary control register, or an on-chip expanded RAM. Accesses that belong off chip become a two-phase cycle on a multiplexed external bus. That bus carries the low address byte and the data byte on the same lines, a separate high address byte, an address-latch strobe, and read and write strobes.

The 80h–FFh range is shared. The addressing mode decides whether a location in that range is a special function register or a byte of upper RAM. Memory-move accesses stay on chip while the expanded-RAM control bit is clear and the address lies below the `XRAM_BYTES` parameter (legal range 256 to 7936). In that case the external pins stay quiet. The auxiliary control register also holds a bit that stops the free-running address-latch pulse. With that bit set, the strobe appears only during external cycles.

The external cycle is driven by a state machine with three states. In XB_IDLE the bus is quiet and new requests are accepted. A request that decodes as external moves it to XB_ADDR, which always moves on to XB_STROBE, which always returns to XB_IDLE. Requests presented while the machine is not in XB_IDLE are ignored.

Top module: `dmem_router`

## Requirements
- R1: With access type 00 (direct) or 01 (indirect) and address bits 7:0 in 00h–7Fh, only `sel_lo` is raised; address bits 15:8 are ignored for these types.
- R2: With address bits 7:0 in 80h–FFh, a direct access raises `sel_sfr`, except at 8Eh, and an indirect access raises `sel_hi` at every address in the range, 8Eh included.
- R3: A direct access at 8Eh raises `sel_aux` and reaches the auxiliary register `aux_q`. That register resets to 02h, a write stores data bits 1:0, and bits 7:2 always read 0. Bit 1 is the expanded-RAM control bit and bit 0 is the strobe-suppression bit.
- R4: While `aux_q[1]` is 0, a memory move through the 8-bit pointer (type 10) always raises `sel_xram`. A move through the 16-bit pointer (type 11) raises `sel_xram` when the full 16-bit address is below `XRAM_BYTES`.
- R5: An access that raises any select leaves `ext_busy`, `ext_rd`, `ext_wr` and `ad_oe` at 0 in the following cycle.
- R6: A type 11 move at or above `XRAM_BYTES`, and any memory move while `aux_q[1]` is 1, raise no select. Such a move starts an address phase in the next cycle, with `ext_busy`=1, `ale`=1, `ad_oe`=1, `ad_out` equal to address bits 7:0 and both strobes at 0.
- R7: During both phases of an external cycle, `addr_hi` carries address bits 15:8 for type 11 and 00h for type 10.
- R8: The cycle after the address phase is the strobe phase. For a write, `ext_wr`=1, `ad_oe`=1 and `ad_out` equals the write data. For a read, `ext_rd`=1 and `ad_oe`=0. The cycle after that returns to idle.
- R9: While `aux_q[0]` is 0 and the bus is idle, `ale` is high for one cycle in every `ALE_DIV` (6) cycles.
- R10: While `aux_q[0]` is 1, `ale` is high only in the address phase of an external cycle.
- R11: While `ext_busy` is 1, requests raise no select and do not write the auxiliary register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_type | input | 2 | 00 direct, 01 indirect, 10 move via 8-bit pointer, 11 move via 16-bit pointer |
| addr | input | 16 | Access address |
| wdata | input | 8 | Write data |
| req_rd | input | 1 | Read request |
| req_wr | input | 1 | Write request (wins if both are set) |
| sel_lo | output | 1 | Lower internal RAM select |
| sel_hi | output | 1 | Upper internal RAM select |
| sel_sfr | output | 1 | Special function register select |
| sel_aux | output | 1 | Auxiliary register select |
| sel_xram | output | 1 | On-chip expanded RAM select |
| aux_q | output | 8 | Auxiliary register contents |
| ext_busy | output | 1 | External cycle in progress |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |
| ad_out | output | 8 | Multiplexed low address / data byte |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| addr_hi | output | 8 | High address byte |
| ale | output | 1 | Address-latch strobe |

## Verification
The bench targets the addresses on either side of each boundary: 7Fh and 80h in both modes, 8Eh reached directly and indirectly, and one below and at `XRAM_BYTES` for the wide pointer. A router that decoded 80h by address alone would send indirect accesses to the register space. An off-by-one size compare would put the last on-chip byte off chip, or the first off-chip byte on chip. It also flips the expanded-RAM bit and then checks the narrow-pointer form. A design that ignored the bit would leave the external pins silent, and one that put the pointer's upper byte on `addr_hi` would show it there. Hostile writes to 8Eh are issued in the middle of a bus cycle, and the free-running strobe period is counted. A design that let busy-time requests through, or miscounted its divider, would show a changed register or the wrong number of pulses.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
    typedef enum logic [1:0] {
        ACC_DIRECT   = 2'd0,
        ACC_INDIRECT = 2'd1,
        ACC_MOVX8    = 2'd2,
        ACC_MOVX16   = 2'd3
    } acc_t;

    typedef enum logic [2:0] {
        TGT_LO   = 3'd0,
        TGT_HI   = 3'd1,
        TGT_SFR  = 3'd2,
        TGT_AUX  = 3'd3,
        TGT_XRAM = 3'd4,
        TGT_EXT  = 3'd5
    } tgt_t;

    localparam logic [7:0] AUX_ADDR  = 8'h8E;
    localparam logic [1:0] AUX_RESET = 2'b10;
endpackage

// File: rtl/dmem_decode.sv
module dmem_decode
    import dmem_pkg::*;
#(
    parameter int XRAM_BYTES = 768
) (
    input  acc_t        acc,
    input  logic [15:0] addr,
    input  logic        xram_off,
    output tgt_t        tgt
);
    localparam logic [16:0] XLIM = 17'(XRAM_BYTES);

    logic upper;
    assign upper = addr[7];

    always_comb begin
        tgt = TGT_LO;
        unique case (acc)
            ACC_DIRECT: begin
                if (!upper)                   tgt = TGT_LO;
                else if (addr[7:0] == AUX_ADDR) tgt = TGT_AUX;
                else                          tgt = TGT_SFR;
            end
            ACC_INDIRECT: tgt = upper ? TGT_HI : TGT_LO;
            ACC_MOVX8:    tgt = xram_off ? TGT_EXT : TGT_XRAM;
            ACC_MOVX16: begin
                if (!xram_off && ({1'b0, addr} < XLIM)) tgt = TGT_XRAM;
                else                                   tgt = TGT_EXT;
            end
            default: tgt = TGT_LO;
        endcase
    end
endmodule

// File: rtl/dmem_auxreg.sv
module dmem_auxreg
    import dmem_pkg::*;
#(
    parameter int ALE_DIV = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wbits,
    output logic [7:0] aux_q,
    output logic       tick
);
    localparam int CW = (ALE_DIV > 1) ? $clog2(ALE_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(ALE_DIV - 1);

    logic [1:0]    bits_q;
    logic [CW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     bits_q <= AUX_RESET;
        else if (wr_en) bits_q <= wbits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                    div_q <= div_q + 1'b1;
    end

    assign tick  = (div_q == LAST);
    assign aux_q = {6'b0, bits_q};

    // R3
    aux_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(aux_q));
    // R9
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/dmem_extbus.sv
module dmem_extbus
    import dmem_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        is_wr,
    input  logic        wide,
    input  logic [15:0] addr,
    input  logic [7:0]  wdata,
    input  logic        ale_off,
    input  logic        tick,
    output logic        busy,
    output logic        ext_rd,
    output logic        ext_wr,
    output logic [7:0]  ad_out,
    output logic        ad_oe,
    output logic [7:0]  addr_hi,
    output logic        ale
);
    typedef enum logic [1:0] {
        XB_IDLE   = 2'd0,
        XB_ADDR   = 2'd1,
        XB_STROBE = 2'd2
    } xb_state_t;

    xb_state_t   state_q, state_d;
    logic [15:0] lat_addr;
    logic [7:0]  lat_wdata;
    logic        lat_wr, lat_wide;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= XB_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_wdata <= '0;
            lat_wr    <= 1'b0;
            lat_wide  <= 1'b0;
        end else if (state_q == XB_IDLE && start) begin
            lat_addr  <= addr;
            lat_wdata <= wdata;
            lat_wr    <= is_wr;
            lat_wide  <= wide;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XB_IDLE:   if (start) state_d = XB_ADDR;
            XB_ADDR:   state_d = XB_STROBE;
            XB_STROBE: state_d = XB_IDLE;
            default:   state_d = XB_IDLE;
        endcase
    end

    always_comb begin
        busy    = 1'b0;
        ext_rd  = 1'b0;
        ext_wr  = 1'b0;
        ad_out  = 8'h00;
        ad_oe   = 1'b0;
        addr_hi = 8'h00;
        unique case (state_q)
            XB_IDLE: ;
            XB_ADDR: begin
                busy    = 1'b1;
                ad_oe   = 1'b1;
                ad_out  = lat_addr[7:0];
                addr_hi = lat_wide ? lat_addr[15:8] : 8'h00;
            end
            XB_STROBE: begin
                busy    = 1'b1;
                ext_rd  = !lat_wr;
                ext_wr  = lat_wr;
                ad_oe   = lat_wr;
                ad_out  = lat_wr ? lat_wdata : 8'h00;
                addr_hi = lat_wide ? lat_addr[15:8] : 8'h00;
            end
            default: ;
        endcase
        ale = (state_q == XB_ADDR) || (!ale_off && tick);
    end

    // R6
    addr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (ale && ad_oe && !ext_rd && !ext_wr));
    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_rd && ext_wr));
    // R8
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rd |-> !ad_oe);
    // R8
    strobe_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_rd || ext_wr) |=> !busy);
endmodule

// File: rtl/dmem_router.sv
module dmem_router
    import dmem_pkg::*;
#(
    parameter int XRAM_BYTES = 768,
    parameter int ALE_DIV    = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  acc_type,
    input  logic [15:0] addr,
    input  logic [7:0]  wdata,
    input  logic        req_rd,
    input  logic        req_wr,
    output logic        sel_lo,
    output logic        sel_hi,
    output logic        sel_sfr,
    output logic        sel_aux,
    output logic        sel_xram,
    output logic [7:0]  aux_q,
    output logic        ext_busy,
    output logic        ext_rd,
    output logic        ext_wr,
    output logic [7:0]  ad_out,
    output logic        ad_oe,
    output logic [7:0]  addr_hi,
    output logic        ale
);
    tgt_t tgt;
    logic active, tick;

    dmem_decode #(.XRAM_BYTES(XRAM_BYTES)) dec_i (
        .acc      (acc_t'(acc_type)),
        .addr     (addr),
        .xram_off (aux_q[1]),
        .tgt      (tgt)
    );

    assign active   = (req_rd || req_wr) && !ext_busy;
    assign sel_lo   = active && (tgt == TGT_LO);
    assign sel_hi   = active && (tgt == TGT_HI);
    assign sel_sfr  = active && (tgt == TGT_SFR);
    assign sel_aux  = active && (tgt == TGT_AUX);
    assign sel_xram = active && (tgt == TGT_XRAM);

    dmem_auxreg #(.ALE_DIV(ALE_DIV)) aux_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (sel_aux && req_wr),
        .wbits (wdata[1:0]),
        .aux_q (aux_q),
        .tick  (tick)
    );

    dmem_extbus bus_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (active && (tgt == TGT_EXT)),
        .is_wr   (req_wr),
        .wide    (acc_type == ACC_MOVX16),
        .addr    (addr),
        .wdata   (wdata),
        .ale_off (aux_q[0]),
        .tick    (tick),
        .busy    (ext_busy),
        .ext_rd  (ext_rd),
        .ext_wr  (ext_wr),
        .ad_out  (ad_out),
        .ad_oe   (ad_oe),
        .addr_hi (addr_hi),
        .ale     (ale)
    );

    // R2
    one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_lo, sel_hi, sel_sfr, sel_aux, sel_xram}));
    // R5
    xram_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_xram |=> (!ext_busy && !ext_rd && !ext_wr && !ad_oe));
    // R10
    ale_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_q[0] && ale) |-> (ext_busy && ad_oe && !ext_rd && !ext_wr));
    // R11
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_busy |=> $stable(aux_q));
    // R3
    aux_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aux_q[7:2] == 6'b0);
endmodule

// File: tb/dmem_router_tb.sv
module dmem_router_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int XB = 768;
    localparam int DIV = 6;
    localparam int T_LO = 0, T_HI = 1, T_SFR = 2, T_AUX = 3, T_XRAM = 4, T_EXT = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0]  acc_type = 2'd0;
    logic [15:0] addr = 16'h0;
    logic [7:0]  wdata = 8'h0;
    logic req_rd = 1'b0, req_wr = 1'b0;
    logic sel_lo, sel_hi, sel_sfr, sel_aux, sel_xram;
    logic [7:0] aux_q, ad_out, addr_hi;
    logic ext_busy, ext_rd, ext_wr, ad_oe, ale;

    int n_chk = 0, n_err = 0;
    logic [1:0] m_aux = 2'b10;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmem_router #(.XRAM_BYTES(XB), .ALE_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_type(acc_type), .addr(addr), .wdata(wdata),
        .req_rd(req_rd), .req_wr(req_wr), .sel_lo(sel_lo), .sel_hi(sel_hi),
        .sel_sfr(sel_sfr), .sel_aux(sel_aux), .sel_xram(sel_xram), .aux_q(aux_q),
        .ext_busy(ext_busy), .ext_rd(ext_rd), .ext_wr(ext_wr), .ad_out(ad_out),
        .ad_oe(ad_oe), .addr_hi(addr_hi), .ale(ale)
    );

    task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic int exp_tgt(input logic [1:0] acc, input logic [15:0] a, input logic xoff);
        case (acc)
            2'd0: return !a[7] ? T_LO : (a[7:0] == 8'h8E ? T_AUX : T_SFR);
            2'd1: return a[7] ? T_HI : T_LO;
            2'd2: return xoff ? T_EXT : T_XRAM;
            default: return (!xoff && int'(a) < XB) ? T_XRAM : T_EXT;
        endcase
    endfunction

    function automatic logic [4:0] sel_vec(input int t);
        case (t)
            T_LO:   return 5'b10000;
            T_HI:   return 5'b01000;
            T_SFR:  return 5'b00100;
            T_AUX:  return 5'b00010;
            T_XRAM: return 5'b00001;
            default: return 5'b00000;
        endcase
    endfunction

    function automatic string tag_of(input int t);
        case (t)
            T_LO:   return "R1";
            T_HI, T_SFR: return "R2";
            T_AUX:  return "R3";
            T_XRAM: return "R4";
            default: return "R6";
        endcase
    endfunction

    task automatic do_access(input logic [1:0] acc, input logic [15:0] a, input logic [7:0] d, input logic wr);
        int t;
        logic [4:0] got;
        logic [7:0] hi_exp;
        t = exp_tgt(acc, a, m_aux[1]);
        hi_exp = (acc == 2'd3) ? a[15:8] : 8'h00;
        @(negedge clk);
        acc_type = acc; addr = a; wdata = d; req_wr = wr; req_rd = !wr;
        #1;
        got = {sel_lo, sel_hi, sel_sfr, sel_aux, sel_xram};
        chk(got == sel_vec(t), tag_of(t), {11'b0, got}, {11'b0, sel_vec(t)});
        if (t == T_AUX && wr) m_aux = d[1:0];
        @(negedge clk);
        if (t == T_EXT) begin
            acc_type = 2'd0; addr = 16'h008E; wdata = {6'b0, ~m_aux}; req_wr = 1'b1; req_rd = 1'b0;
            #1;
            got = {sel_lo, sel_hi, sel_sfr, sel_aux, sel_xram};
            chk(got == 5'b0, "R11", {11'b0, got}, 16'h0);
            chk(ext_busy && ale && ad_oe && !ext_rd && !ext_wr, "R6",
                {11'b0, ext_busy, ale, ad_oe, ext_rd, ext_wr}, 16'h1C);
            chk(ad_out == a[7:0], "R6", {8'b0, ad_out}, {8'b0, a[7:0]});
            chk(addr_hi == hi_exp, "R7", {8'b0, addr_hi}, {8'b0, hi_exp});
            @(negedge clk);
            req_wr = 1'b0;
            #1;
            chk(ext_wr == wr && ext_rd == !wr && ad_oe == wr, "R8",
                {13'b0, ext_wr, ext_rd, ad_oe}, {13'b0, wr, !wr, wr});
            if (wr) chk(ad_out == d, "R8", {8'b0, ad_out}, {8'b0, d});
            chk(addr_hi == hi_exp, "R7", {8'b0, addr_hi}, {8'b0, hi_exp});
            if (m_aux[0]) chk(!ale, "R10", {15'b0, ale}, 16'h0);
            @(negedge clk);
            #1;
            chk(!ext_busy, "R8", {15'b0, ext_busy}, 16'h0);
            chk(aux_q == {6'b0, m_aux}, "R11", {8'b0, aux_q}, {14'b0, m_aux});
        end else begin
            req_rd = 1'b0; req_wr = 1'b0;
            #1;
            chk(!ext_busy && !ext_rd && !ext_wr && !ad_oe, "R5",
                {12'b0, ext_busy, ext_rd, ext_wr, ad_oe}, 16'h0);
            chk(aux_q == {6'b0, m_aux}, "R3", {8'b0, aux_q}, {14'b0, m_aux});
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int cnt, last, gap_bad;
        logic [1:0] acc;
        logic [15:0] a;
        void'($urandom(32'd20240611));
        #(CLK_PERIOD * 3);
        @(negedge clk);
        #1;
        chk(aux_q == 8'h02, "R3", {8'b0, aux_q}, 16'h0002);
        chk(!ext_busy && !ext_rd && !ext_wr && !ad_oe, "R5",
            {12'b0, ext_busy, ext_rd, ext_wr, ad_oe}, 16'h0);
        rst_n = 1'b1;

        // directed boundaries
        do_access(2'd0, 16'h007F, 8'h11, 1'b1);   // R1
        do_access(2'd1, 16'hAB7F, 8'h11, 1'b0);   // R1
        do_access(2'd0, 16'h0080, 8'h22, 1'b0);   // R2
        do_access(2'd1, 16'h0080, 8'h22, 1'b1);   // R2
        do_access(2'd1, 16'h008E, 8'h33, 1'b1);   // R2 indirect 8Eh
        do_access(2'd0, 16'h008E, 8'hFC, 1'b1);   // R3 reserved bits dropped
        do_access(2'd2, 16'h00FF, 8'h44, 1'b1);   // R4
        do_access(2'd3, 16'(XB - 1), 8'h55, 1'b0); // R4
        do_access(2'd3, 16'(XB), 8'h66, 1'b1);    // R6
        do_access(2'd3, 16'hBEEF, 8'h77, 1'b0);   // R7
        do_access(2'd0, 16'h008E, 8'h03, 1'b1);   // R3 external mode, no free ALE
        do_access(2'd2, 16'h0012, 8'h88, 1'b1);   // R7 high byte zero
        do_access(2'd3, 16'h0005, 8'h99, 1'b0);   // R6 low address external

        // R10 idle with suppression set
        cnt = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk); #1;
            if (ale) cnt++;
        end
        chk(cnt == 0, "R10", 16'(cnt), 16'h0);

        // R9 free-running strobe
        do_access(2'd0, 16'h008E, 8'h00, 1'b1);
        cnt = 0; last = -1; gap_bad = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk); #1;
            if (ale) begin
                if (last >= 0 && i - last != DIV) gap_bad++;
                last = i; cnt++;
            end
        end
        chk(cnt == 60 / DIV, "R9", 16'(cnt), 16'(60 / DIV));
        chk(gap_bad == 0, "R9", 16'(gap_bad), 16'h0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            if (i % 40 == 0) do_access(2'd0, 16'h008E, 8'($urandom), 1'b1);
            acc = 2'($urandom);
            a = 16'($urandom);
            if (acc == 2'd3 && $urandom % 2 == 0) a = 16'($urandom % (2 * XB));
            do_access(acc, a, 8'($urandom), 1'($urandom));
        end

        finish_run();
    end
endmodule